// File: doc/BRIEF.md
# Processor-Side Bus Arbitration Controller

This block decides when a processor hands its external bus to another master and when it takes the bus back. Another master raises an asynchronous request. The controller answers with an active-high grant and an internal three-state control. The requester then asserts an asynchronous acknowledge to confirm that it owns the bus. It releases the bus by dropping that acknowledge. The controller also runs in a 2-wire mode, where the acknowledge is ignored and the request alone decides ownership.

The request and acknowledge are brought into the clock domain on falling edges. The arbitration state machine moves on rising edges. The processor's bus-cycle sequencer appears only through four inputs:
- the address strobe;
- a flag for the first two phases of a bus cycle, during which the machine holds its state;
- a flag saying that a cycle has been committed but its strobe is not yet out;
- the mode select.

The buses actually float only while the three-state control is set and the address strobe is low. A separate output tells the sequencer when it may start a new external cycle.

Top module: `busarb_top`

## Requirements
- R1: A synchronous reset, held across at least two clock cycles, leaves the grant, the three-state control and the float output low, sets the may-start output high, and clears both synchronizer stages.
- R2: A request (busReq, active high) applied between two rising edges raises the grant on the second following rising edge and not on the first.
- R3: The three-state control rises together with the grant. The float output equals the three-state control gated by a low address strobe, and it follows the strobe within the same cycle.
- R4: In 3-wire mode (twoWireMode=0), an acknowledge seen while granted drops the grant two rising edges later and keeps the three-state control high. Acknowledge takes priority over a request withdrawn at the same time.
- R5: In 3-wire mode, when the acknowledge drops with no request pending, the three-state control falls two rising edges later and may-start returns high.
- R6: In 3-wire mode, when the acknowledge drops while a request is still pending, the grant is asserted again two rising edges later. The three-state control stays high and may-start stays low throughout.
- R7: A request withdrawn before any acknowledge is seen removes the grant and the three-state control two rising edges later.
- R8: While phaseEarly is high, the machine holds its state. An idle controller does not grant, and a released bus is not taken back until phaseEarly drops.
- R9: If the synchronized request is found while cycleCommitted is high and the address strobe is low, the grant is delayed to the third rising edge after the request, one edge later than R2. phaseEarly does not hold this delayed grant back.
- R10: In 2-wire mode (twoWireMode=1), the acknowledge input has no effect. The grant stays high while the request is held and falls, together with the three-state control, two rising edges after the request drops.
- R11: The may-start output is low whenever the grant or the three-state control is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; synchronizers on falling edge, state on rising edge |
| rst | input | 1 | Synchronous reset, active high |
| busReq | input | 1 | Asynchronous bus request from another master, active high |
| busAck | input | 1 | Asynchronous ownership acknowledge, active high |
| addrStrobe | input | 1 | Processor address strobe, active high |
| phaseEarly | input | 1 | High while the processor's bus cycle is in its first two phases |
| cycleCommitted | input | 1 | High once a bus cycle is decided but before its strobe is asserted |
| twoWireMode | input | 1 | 1 selects 2-wire arbitration (acknowledge ignored) |
| busGrant | output | 1 | Bus grant, active high |
| busThreeState | output | 1 | Internal three-state control: processor must release the bus |
| busFloat | output | 1 | Pad enable to float address, data and control buses |
| cpuMayStart | output | 1 | Processor may begin an external bus cycle |

## Verification
The bench samples the grant on both the first and the second rising edge after a request. A design that used the raw input, or that added a synchronizer stage, fails the latency check. The committed-before-strobe case is held in the early phases on purpose. A design that applied the phase hold to that path would never grant, and one that skipped the extra edge would grant one cycle early. The release paths are driven with the request still pending and with it withdrawn. These runs catch a machine that drops the three-state control before regranting, or that lets may-start pulse high in between. In 2-wire mode a stray acknowledge is applied while granted; a design that honoured it would drop the grant.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_HOLDOFF  = 2'd1,
    ST_GRANTED  = 2'd2,
    ST_RELEASED = 2'd3
  } arbState_t;

  typedef struct packed {
    logic grantNext;
    logic threeStateNext;
  } arbStrobe_t;

  localparam int SYNC_WIDTH = 2;
  localparam int REQ_BIT    = 0;
  localparam int ACK_BIT    = 1;

endpackage

// File: rtl/busarb_datapath.sv
module busarb_datapath
  import busarb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       busReq,
  input  logic       busAck,
  input  logic       addrStrobe,
  input  arbStrobe_t strobes,
  output logic       reqSync,
  output logic       ackSync,
  output logic       busGrant,
  output logic       busThreeState,
  output logic       busFloat,
  output logic       cpuMayStart
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][SYNC_WIDTH-1:0] syncChain;
  logic [SYNC_WIDTH-1:0] asyncIn;
  logic grantQ;
  logic threeQ;

  always_comb begin
    asyncIn          = '0;
    asyncIn[REQ_BIT] = busReq;
    asyncIn[ACK_BIT] = busAck;
  end

  // falling-edge capture: first stage samples, last stage is valid internally
  always_ff @(negedge clk) begin
    if (rst) begin
      syncChain <= '0;
    end else begin
      syncChain[0] <= asyncIn;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        syncChain[i] <= syncChain[i-1];
      end
    end
  end

  assign reqSync = syncChain[LAST][REQ_BIT];
  assign ackSync = syncChain[LAST][ACK_BIT];

  // outputs registered on the rising edge from the control strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      grantQ <= 1'b0;
      threeQ <= 1'b0;
    end else begin
      grantQ <= strobes.grantNext;
      threeQ <= strobes.threeStateNext;
    end
  end

  assign busGrant      = grantQ;
  assign busThreeState = threeQ;
  assign busFloat      = threeQ & ~addrStrobe;
  assign cpuMayStart   = ~(grantQ | threeQ);

endmodule

// File: rtl/busarb_ctrl.sv
module busarb_ctrl
  import busarb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqSync,
  input  logic       ackSync,
  input  logic       addrStrobe,
  input  logic       phaseEarly,
  input  logic       cycleCommitted,
  input  logic       twoWireMode,
  output arbStrobe_t strobes
);

  arbState_t state;
  arbState_t stateNext;
  logic      ackEff;
  logic      strobePending;

  assign ackEff        = ackSync & ~twoWireMode;
  assign strobePending = cycleCommitted & ~addrStrobe;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqSync && strobePending) begin
          stateNext = ST_HOLDOFF;
        end else if (reqSync && !phaseEarly) begin
          stateNext = ST_GRANTED;
        end
      end
      ST_HOLDOFF: begin
        stateNext = reqSync ? ST_GRANTED : ST_IDLE;
      end
      ST_GRANTED: begin
        if (!phaseEarly) begin
          if (ackEff) begin
            stateNext = ST_RELEASED;
          end else if (!reqSync) begin
            stateNext = ST_IDLE;
          end
        end
      end
      ST_RELEASED: begin
        if (!phaseEarly && !ackEff) begin
          stateNext = reqSync ? ST_GRANTED : ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    strobes.grantNext      = (stateNext == ST_GRANTED);
    strobes.threeStateNext = (stateNext == ST_GRANTED) || (stateNext == ST_RELEASED);
  end

endmodule

// File: rtl/busarb_top.sv
module busarb_top
  import busarb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic busReq,
  input  logic busAck,
  input  logic addrStrobe,
  input  logic phaseEarly,
  input  logic cycleCommitted,
  input  logic twoWireMode,
  output logic busGrant,
  output logic busThreeState,
  output logic busFloat,
  output logic cpuMayStart
);

  arbStrobe_t strobes;
  logic       reqSync;
  logic       ackSync;

  busarb_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .reqSync       (reqSync),
    .ackSync       (ackSync),
    .addrStrobe    (addrStrobe),
    .phaseEarly    (phaseEarly),
    .cycleCommitted(cycleCommitted),
    .twoWireMode   (twoWireMode),
    .strobes       (strobes)
  );

  busarb_datapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .busReq       (busReq),
    .busAck       (busAck),
    .addrStrobe   (addrStrobe),
    .strobes      (strobes),
    .reqSync      (reqSync),
    .ackSync      (ackSync),
    .busGrant     (busGrant),
    .busThreeState(busThreeState),
    .busFloat     (busFloat),
    .cpuMayStart  (cpuMayStart)
  );

endmodule

// File: rtl/busarb_checker.sv
module busarb_checker (
  input logic clk,
  input logic rst,
  input logic phaseEarly,
  input logic twoWireMode,
  input logic busGrant,
  input logic busThreeState,
  input logic cpuMayStart
);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busGrant && !busThreeState && cpuMayStart)); // R1

  AST_GRANT_WITH_THREE_STATE: assert property (@(posedge clk) disable iff (rst)
    busGrant |-> busThreeState); // R3

  AST_FREEZE_KEEPS_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ($past(phaseEarly) && $past(busThreeState) && !$past(busGrant)) |-> busThreeState); // R8

  AST_TWO_WIRE_NO_HANDOFF: assert property (@(posedge clk) disable iff (rst)
    twoWireMode |-> !($fell(busGrant) && busThreeState)); // R10

endmodule

bind busarb_top busarb_checker u_checker (
  .clk          (clk),
  .rst          (rst),
  .phaseEarly   (phaseEarly),
  .twoWireMode  (twoWireMode),
  .busGrant     (busGrant),
  .busThreeState(busThreeState),
  .cpuMayStart  (cpuMayStart)
);

// File: tb/tb_busarb_top.sv
`timescale 1ns/1ps
module tb_busarb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busReq = 1'b0;
  logic busAck = 1'b0;
  logic addrStrobe = 1'b0;
  logic phaseEarly = 1'b0;
  logic cycleCommitted = 1'b0;
  logic twoWireMode = 1'b0;
  logic busGrant;
  logic busThreeState;
  logic busFloat;
  logic cpuMayStart;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  busarb_top dut (
    .clk           (clk),
    .rst           (rst),
    .busReq        (busReq),
    .busAck        (busAck),
    .addrStrobe    (addrStrobe),
    .phaseEarly    (phaseEarly),
    .cycleCommitted(cycleCommitted),
    .twoWireMode   (twoWireMode),
    .busGrant      (busGrant),
    .busThreeState (busThreeState),
    .busFloat      (busFloat),
    .cpuMayStart   (cpuMayStart)
  );

  // advance to 5 ns after the next rising edge: sample and drive point
  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #5;
    end
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic checkOuts(input string req, input logic g, input logic t, input logic f, input logic m);
    check(req, "busGrant", busGrant, g);
    check(req, "busThreeState", busThreeState, t);
    check(req, "busFloat", busFloat, f);
    check(req, "cpuMayStart", cpuMayStart, m);
  endtask

  task automatic doReset(input logic mode);
    rst = 1'b1;
    busReq = 1'b0;
    busAck = 1'b0;
    addrStrobe = 1'b0;
    phaseEarly = 1'b0;
    cycleCommitted = 1'b0;
    twoWireMode = mode;
    tick(3);
    rst = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // R1: reset state, and a request held through reset starts fresh afterwards
  task automatic testReset();
    doReset(1'b0);
    busReq = 1'b1;
    rst = 1'b1;
    tick(3);
    checkOuts("R1", 1'b0, 1'b0, 1'b0, 1'b1);
    busReq = 1'b0;
    tick(3);
    rst = 1'b0;
    tick(2);
    checkOuts("R1", 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  // R2 R3 R4 R5 R11: full 3-wire handoff with bus idle
  task automatic testHandoff();
    doReset(1'b0);
    busReq = 1'b1;
    tick(1);
    check("R2", "grant on first edge", busGrant, 1'b0);
    tick(1);
    checkOuts("R2", 1'b1, 1'b1, 1'b1, 1'b0);
    check("R11", "mayStart while granted", cpuMayStart, 1'b0);
    addrStrobe = 1'b1;
    #1;
    check("R3", "float with strobe high", busFloat, 1'b0);
    addrStrobe = 1'b0;
    #1;
    check("R3", "float with strobe low", busFloat, 1'b1);
    busAck = 1'b1;
    busReq = 1'b0;
    tick(1);
    check("R4", "grant before ack synced", busGrant, 1'b1);
    tick(1);
    checkOuts("R4", 1'b0, 1'b1, 1'b1, 1'b0);
    busAck = 1'b0;
    tick(1);
    check("R5", "threeState before release", busThreeState, 1'b1);
    tick(1);
    checkOuts("R5", 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  // R6: acknowledge dropped with another request pending
  task automatic testRegrant();
    doReset(1'b0);
    busReq = 1'b1;
    tick(2);
    busAck = 1'b1;
    tick(2);
    check("R6", "grant dropped after ack", busGrant, 1'b0);
    busAck = 1'b0;
    tick(1);
    checkOuts("R6", 1'b0, 1'b1, 1'b1, 1'b0);
    tick(1);
    checkOuts("R6", 1'b1, 1'b1, 1'b1, 1'b0);
    busReq = 1'b0;
    tick(2);
    check("R7", "grant after withdraw", busGrant, 1'b0);
  endtask

  // R7: request withdrawn before acknowledge
  task automatic testWithdraw();
    doReset(1'b0);
    busReq = 1'b1;
    tick(2);
    check("R7", "granted", busGrant, 1'b1);
    busReq = 1'b0;
    tick(1);
    check("R7", "grant held one edge", busGrant, 1'b1);
    tick(1);
    checkOuts("R7", 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  // R8: early phases hold both the idle and the released states
  task automatic testFreeze();
    doReset(1'b0);
    phaseEarly = 1'b1;
    busReq = 1'b1;
    tick(4);
    check("R8", "no grant while frozen", busGrant, 1'b0);
    phaseEarly = 1'b0;
    tick(1);
    check("R8", "grant after unfreeze", busGrant, 1'b1);
    busAck = 1'b1;
    busReq = 1'b0;
    tick(2);
    check("R8", "released state", busThreeState, 1'b1);
    phaseEarly = 1'b1;
    busAck = 1'b0;
    tick(4);
    check("R8", "release held while frozen", busThreeState, 1'b1);
    phaseEarly = 1'b0;
    tick(1);
    checkOuts("R8", 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  // R9: request arrives with a committed cycle whose strobe is not out yet
  task automatic testDelayedGrant();
    doReset(1'b0);
    phaseEarly = 1'b1;
    cycleCommitted = 1'b1;
    busReq = 1'b1;
    tick(2);
    check("R9", "no grant on second edge", busGrant, 1'b0);
    cycleCommitted = 1'b0;
    addrStrobe = 1'b1;
    tick(1);
    checkOuts("R9", 1'b1, 1'b1, 1'b0, 1'b0);
    addrStrobe = 1'b0;
    #1;
    check("R3", "float once strobe drops", busFloat, 1'b1);
    phaseEarly = 1'b0;
    busReq = 1'b0;
    tick(2);
    checkOuts("R9", 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  // R10: 2-wire mode ignores the acknowledge
  task automatic testTwoWire();
    doReset(1'b1);
    busReq = 1'b1;
    tick(2);
    check("R10", "grant in 2-wire", busGrant, 1'b1);
    busAck = 1'b1;
    tick(3);
    checkOuts("R10", 1'b1, 1'b1, 1'b1, 1'b0);
    busReq = 1'b0;
    tick(1);
    check("R10", "grant held one edge", busGrant, 1'b1);
    tick(1);
    checkOuts("R10", 1'b0, 1'b0, 1'b0, 1'b1);
    busAck = 1'b0;
  endtask

  initial begin
    testReset();
    testHandoff();
    testRegrant();
    testWithdraw();
    testFreeze();
    testDelayedGrant();
    testTwoWire();
    finishRun();
  end

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

endmodule